// File: doc/BRIEF.md
# Coexistence-Aware Reception Statistics Recorder

This block follows one received PPDU from its start strobe to its end strobe and then emits a fixed 13-word status record on a 32-bit valid/ready stream. While the PPDU is in progress it tallies completed MPDUs by FCS result. It splits those tallies at the moment a coexistence transmitter (BT, WAN or another WLAN radio) first turns on. For each of the three transmitters it notes whether it was already on when reception began, or switched on during reception. It also flags MPDU delimiter errors and measures the reception length in microseconds.

A divided-down microsecond tick drives a free-running 64-bit timestamp. The timestamp is captured at PPDU start and at PPDU end. A 2-bit frame-kind code and two token bytes are sampled at PPDU end. A new PPDU start is only accepted once the previous record has been fully handed over.

Top module: `ppdu_end_stats`

## Requirements
- R1: After synchronous reset `rec_valid` is low and the block waits for a PPDU start.
- R2: Word 5 holds four 8-bit MPDU tallies: bits [7:0] FCS-pass before the coex boundary, [15:8] FCS-fail before, [23:16] FCS-pass after, [31:24] FCS-fail after. MPDU completions count from the cycle after the start strobe up to and including the end-strobe cycle.
- R3: The boundary is the first 0-to-1 transition of any `coex_active` line after PPDU start, or PPDU start itself if any line is already high then. An MPDU completing in the same cycle as that transition, or later, goes into the after group.
- R4: Word 4 bits [5:0] hold, in the order BT-from, BT-after, WAN-from, WAN-after, WLAN-from, WLAN-after, the per-source flags. `coex_active` bit 0 is BT, bit 1 is WAN and bit 2 is WLAN. A "from" flag is the line's level at the start strobe. An "after" flag is set by a 0-to-1 transition of the line while receiving.
- R5: Word 4 bit 6 is set if `delim_err` pulsed at any time during the PPDU. It stays set until the PPDU ends and is cleared by the next PPDU start.
- R6: Word 6 bits [DUR_W-1:0] count microsecond ticks while receiving and saturate at 2^DUR_W-1. DUR_W is at most 24, and the upper bits of the word are zero.
- R7: A 64-bit timestamp advances once per TICK_DIV clocks. Words 0 and 1 hold its low and high halves at PPDU start, and words 2 and 3 hold them at PPDU end.
- R8: Word 4 bits [8:7] hold the frame kind (0 none, 1 FTM, 2 TM, 3 reserved), [16:9] the dialog token and [24:17] the follow-up token, all sampled at PPDU end. Kind 0 forces the tokens to 254 and 255.
- R9: Every MPDU tally saturates at 255 instead of wrapping.
- R10: The record is 13 words sent in index order. `rec_last` is high only on word 12, which is 0xAABBCCDD. Words 7 to 11 are zero. Data and last hold steady while valid is high and ready is low.
- R11: `ppdu_start` is ignored while a PPDU is being received or a record is being sent, and `ppdu_end` is ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ppdu_start | input | 1 | PPDU start strobe |
| ppdu_end | input | 1 | PPDU end strobe |
| mpdu_done | input | 1 | One MPDU completed this cycle |
| mpdu_fcs_ok | input | 1 | FCS result of that MPDU (1 = pass) |
| delim_err | input | 1 | MPDU delimiter error pulse |
| coex_active | input | 3 | Transmit-active lines: bit 0 BT, bit 1 WAN, bit 2 WLAN |
| frame_kind | input | 2 | Timing frame kind code |
| token_dialog | input | 8 | Dialog token byte |
| token_follow | input | 8 | Follow-up dialog token byte |
| rec_ready | input | 1 | Record sink ready |
| rec_valid | output | 1 | Record word valid |
| rec_data | output | 32 | Record word |
| rec_last | output | 1 | Final record word |

## Verification
The bench aims at the cycle where a coex line rises together with an MPDU completion. A design that samples the boundary only from its register would put that MPDU in the before group. It also covers a line already high at start: a design that waits for an edge would count every MPDU as before and miss the "from" flag. It pushes more than 255 MPDUs and more than 255 ticks through a narrow duration setting, which exposes counters that wrap instead of saturating. It pulses start during reception and during a stalled record, and pulses end while idle; a design that accepted any of these would clear tallies, restart early or emit a spurious record. Word-by-word comparison against a behavioural model under alternating backpressure catches misordered, misplaced or unstable record words.

// File: rtl/ppdu_stats_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the reception statistics recorder.
// Assumes a 32-bit record stream and three coexistence sources.
package ppdu_stats_pkg;
    localparam int WORD_W    = 32;
    localparam int REC_WORDS = 13;
    localparam int IDX_W     = $clog2(REC_WORDS);
    localparam int CNT_W     = 8;
    localparam int TS_W      = 64;
    localparam int N_COEX    = 3;
    localparam int N_TALLY   = 4;

    localparam logic [WORD_W-1:0] END_MARKER   = 32'hAABB_CCDD;
    localparam logic [7:0]        NOFTM_DIALOG = 8'd254;
    localparam logic [7:0]        NOFTM_FOLLOW = 8'd255;

    // Record word positions
    localparam int W_TS_START_LO = 0;
    localparam int W_TS_START_HI = 1;
    localparam int W_TS_END_LO   = 2;
    localparam int W_TS_END_HI   = 3;
    localparam int W_STATUS      = 4;
    localparam int W_TALLY       = 5;
    localparam int W_DURATION    = 6;
    localparam int W_MARKER      = REC_WORDS - 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RX   = 2'd1,
        PH_SEND = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_FTM  = 2'd1,
        FK_TM   = 2'd2,
        FK_RSVD = 2'd3
    } frame_kind_e;
endpackage

// File: rtl/usec_timebase.sv
`timescale 1ns/1ps
// Microsecond timebase: divides clk by TICK_DIV into a one-cycle tick
// and advances a free-running 64-bit timestamp on each tick.
// Assumes TICK_DIV >= 1 clocks per microsecond.
module usec_timebase
    import ppdu_stats_pkg::*;
#(
    parameter int TICK_DIV = 50
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            tick,
    output logic [TS_W-1:0] ts
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_q;

    assign tick = (div_q == DIV_LAST);

    // Prescaler: count clocks within one microsecond
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

    // Timestamp: advance by one per microsecond tick
    always_ff @(posedge clk) begin
        if (!rst_n)    ts <= '0;
        else if (tick) ts <= ts + 1'b1;
    end

    // R7: the timestamp never jumps by more than one
    a_r7_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ts == $past(ts)) || (ts == $past(ts) + 1'b1));
endmodule

// File: rtl/coex_monitor.sv
`timescale 1ns/1ps
// Coexistence monitor: records per-source "already on at start" and
// "switched on during reception" flags, and tracks the before/after
// boundary used to split MPDU tallies. The boundary output includes an
// edge seen in the current cycle so a simultaneous MPDU lands "after".
// Assumes start_evt only occurs while not receiving.
module coex_monitor
    import ppdu_stats_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              in_rx,
    input  logic [N_COEX-1:0] coex_act,
    output logic [N_COEX-1:0] from_flags,
    output logic [N_COEX-1:0] after_flags,
    output logic              after_now
);
    logic [N_COEX-1:0] coex_q;
    logic [N_COEX-1:0] rise;
    logic              bnd_q;

    assign rise      = coex_act & ~coex_q;
    assign after_now = bnd_q | (in_rx & (|rise));

    // Edge detector history
    always_ff @(posedge clk) begin
        if (!rst_n) coex_q <= '0;
        else        coex_q <= coex_act;
    end

    // Boundary latch: set by a line high at start or any edge while receiving
    always_ff @(posedge clk) begin
        if (!rst_n)                bnd_q <= 1'b0;
        else if (start_evt)        bnd_q <= |coex_act;
        else if (in_rx && (|rise)) bnd_q <= 1'b1;
    end

    for (genvar s = 0; s < N_COEX; s++) begin : g_src
        // Per-source flags: level at start, edge during reception
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                from_flags[s]  <= 1'b0;
                after_flags[s] <= 1'b0;
            end else if (start_evt) begin
                from_flags[s]  <= coex_act[s];
                after_flags[s] <= 1'b0;
            end else if (in_rx && rise[s]) begin
                after_flags[s] <= 1'b1;
            end
        end

        // R4: an after flag only appears following a rising line
        a_r4_after_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (in_rx && !after_flags[s]) ##1 after_flags[s] |-> $past(coex_act[s]));
    end

    // R3: once the boundary is crossed it holds for the rest of the PPDU
    a_r3_boundary_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rx && bnd_q) |=> bnd_q);

    // R4: from flags do not move while receiving
    a_r4_from_stable: assert property (@(posedge clk) disable iff (!rst_n)
        in_rx |=> $stable(from_flags));
endmodule

// File: rtl/mpdu_tally.sv
`timescale 1ns/1ps
// MPDU tally bank: four saturating counters indexed by
// {after boundary, FCS failed}. Assumes clear and counting never coincide.
module mpdu_tally
    import ppdu_stats_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           count_en,
    input  logic                           mpdu_done,
    input  logic                           fcs_ok,
    input  logic                           after_sel,
    output logic [N_TALLY-1:0][CNT_W-1:0]  counts
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [1:0] sel;
    assign sel = {after_sel, ~fcs_ok};

    for (genvar g = 0; g < N_TALLY; g++) begin : g_cnt
        // Saturating counter for one pass/fail, before/after bin
        always_ff @(posedge clk) begin
            if (!rst_n)
                counts[g] <= '0;
            else if (clear)
                counts[g] <= '0;
            else if (count_en && mpdu_done && (sel == 2'(g)) && (counts[g] != CNT_MAX))
                counts[g] <= counts[g] + 1'b1;
        end

        // R9: a full counter stays full until cleared
        a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (counts[g] == CNT_MAX && !clear) |=> counts[g] == CNT_MAX);
    end

    // R2: at most one bin moves per cycle, and only by one
    a_r2_one_bin: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ($countones({counts[0] != $past(counts[0]), counts[1] != $past(counts[1]),
                                counts[2] != $past(counts[2]), counts[3] != $past(counts[3])}) <= 1));
endmodule

// File: rtl/record_emitter.sv
`timescale 1ns/1ps
// Record emitter: on launch, walks the 13 record words out in index
// order on a valid/ready stream and pulses done on the final handshake.
// Assumes the word vector is held stable while sending.
module record_emitter
    import ppdu_stats_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              launch,
    input  logic [REC_WORDS-1:0][WORD_W-1:0]  words,
    input  logic                              rec_ready,
    output logic                              rec_valid,
    output logic [WORD_W-1:0]                 rec_data,
    output logic                              rec_last,
    output logic                              done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_WORDS - 1);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;

    assign rec_valid = busy_q;
    assign rec_last  = busy_q && (idx_q == LAST_IDX);
    assign done      = rec_valid && rec_ready && rec_last;

    // Word select for the current index
    always_comb begin
        rec_data = '0;
        if (busy_q && idx_q <= LAST_IDX) rec_data = words[idx_q];
    end

    // Sequencer: start on launch, advance on each accepted word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q && rec_ready) begin
            if (idx_q == LAST_IDX) busy_q <= 1'b0;
            else                   idx_q  <= idx_q + 1'b1;
        end
    end

    // R10: a stalled word is held unchanged
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> rec_valid && $stable(rec_data) && $stable(rec_last));

    // R10: the closing word carries the alignment marker
    a_r10_marker_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        rec_last |-> rec_data == END_MARKER);

    // R11: no launch while a record is still going out
    a_r11_launch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy_q);
endmodule

// File: rtl/ppdu_end_stats.sv
`timescale 1ns/1ps
// Reception statistics recorder top: sequences idle / receive / send,
// gathers tallies, coex flags, delimiter error, duration, timestamps and
// frame tokens, then hands a 13-word record to the emitter.
// Assumes DUR_W <= 24 and strobes are single-cycle pulses.
module ppdu_end_stats
    import ppdu_stats_pkg::*;
#(
    parameter int TICK_DIV = 50,
    parameter int DUR_W    = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ppdu_start,
    input  logic        ppdu_end,
    input  logic        mpdu_done,
    input  logic        mpdu_fcs_ok,
    input  logic        delim_err,
    input  logic [2:0]  coex_active,
    input  logic [1:0]  frame_kind,
    input  logic [7:0]  token_dialog,
    input  logic [7:0]  token_follow,
    input  logic        rec_ready,
    output logic        rec_valid,
    output logic [31:0] rec_data,
    output logic        rec_last
);
    localparam logic [DUR_W-1:0] DUR_MAX = '1;

    phase_e                              phase_q;
    logic                                start_evt, end_evt, in_rx, emit_done;
    logic                                tick;
    logic [TS_W-1:0]                     ts_now, ts_start_q, ts_end_q;
    logic [N_COEX-1:0]                   from_flags, after_flags;
    logic [2*N_COEX-1:0]                 coex_bits;
    logic                                after_now;
    logic [N_TALLY-1:0][CNT_W-1:0]       counts;
    logic                                delim_q;
    logic [DUR_W-1:0]                    dur_q;
    logic [1:0]                          kind_q;
    logic [7:0]                          dlg_q, fup_q;
    logic [REC_WORDS-1:0][WORD_W-1:0]    words;

    assign in_rx     = (phase_q == PH_RX);
    assign start_evt = (phase_q == PH_IDLE) && ppdu_start;
    assign end_evt   = in_rx && ppdu_end;

    // Phase sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else begin
            case (phase_q)
                PH_IDLE: if (ppdu_start) phase_q <= PH_RX;
                PH_RX:   if (ppdu_end)   phase_q <= PH_SEND;
                PH_SEND: if (emit_done)  phase_q <= PH_IDLE;
                default:                 phase_q <= PH_IDLE;
            endcase
        end
    end

    usec_timebase #(.TICK_DIV(TICK_DIV)) u_timebase (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .ts   (ts_now)
    );

    coex_monitor u_coex (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_evt  (start_evt),
        .in_rx      (in_rx),
        .coex_act   (coex_active),
        .from_flags (from_flags),
        .after_flags(after_flags),
        .after_now  (after_now)
    );

    mpdu_tally u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_evt),
        .count_en (in_rx),
        .mpdu_done(mpdu_done),
        .fcs_ok   (mpdu_fcs_ok),
        .after_sel(after_now),
        .counts   (counts)
    );

    // Interleave per-source flags as from/after pairs
    for (genvar s = 0; s < N_COEX; s++) begin : g_flag
        assign coex_bits[2*s]   = from_flags[s];
        assign coex_bits[2*s+1] = after_flags[s];
    end

    // Sticky delimiter error flag
    always_ff @(posedge clk) begin
        if (!rst_n)                  delim_q <= 1'b0;
        else if (start_evt)          delim_q <= 1'b0;
        else if (in_rx && delim_err) delim_q <= 1'b1;
    end

    // Saturating reception duration in microseconds
    always_ff @(posedge clk) begin
        if (!rst_n)                                dur_q <= '0;
        else if (start_evt)                        dur_q <= '0;
        else if (in_rx && tick && dur_q != DUR_MAX) dur_q <= dur_q + 1'b1;
    end

    // Timestamp capture at start and end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_start_q <= '0;
            ts_end_q   <= '0;
        end else begin
            if (start_evt) ts_start_q <= ts_now;
            if (end_evt)   ts_end_q   <= ts_now;
        end
    end

    // Frame kind and token capture at end, with the non-timing defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= '0;
            dlg_q  <= '0;
            fup_q  <= '0;
        end else if (end_evt) begin
            kind_q <= frame_kind;
            if (frame_kind == FK_NONE) begin
                dlg_q <= NOFTM_DIALOG;
                fup_q <= NOFTM_FOLLOW;
            end else begin
                dlg_q <= token_dialog;
                fup_q <= token_follow;
            end
        end
    end

    // Record assembly; unlisted words stay zero
    always_comb begin
        words                = '0;
        words[W_TS_START_LO] = ts_start_q[31:0];
        words[W_TS_START_HI] = ts_start_q[63:32];
        words[W_TS_END_LO]   = ts_end_q[31:0];
        words[W_TS_END_HI]   = ts_end_q[63:32];
        words[W_STATUS]      = {7'b0, fup_q, dlg_q, kind_q, delim_q, coex_bits};
        words[W_TALLY]       = counts;
        words[W_DURATION]    = WORD_W'(dur_q);
        words[W_MARKER]      = END_MARKER;
    end

    record_emitter u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (end_evt),
        .words    (words),
        .rec_ready(rec_ready),
        .rec_valid(rec_valid),
        .rec_data (rec_data),
        .rec_last (rec_last),
        .done     (emit_done)
    );

    // R5: delimiter flag sticks through reception
    a_r5_delim_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rx && delim_q) |=> delim_q);

    // R6: duration holds at its ceiling
    a_r6_dur_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (dur_q == DUR_MAX && !start_evt) |=> dur_q == DUR_MAX);

    // R11: start capture untouched outside idle
    a_r11_start_held: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> $stable(ts_start_q));

    // R8: non-timing frames present forced tokens in the record
    a_r8_token_force: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && kind_q == FK_NONE) |-> (dlg_q == NOFTM_DIALOG && fup_q == NOFTM_FOLLOW));

    // R10: record output only while in the send phase
    a_r10_valid_phase: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> phase_q == PH_SEND);
endmodule

// File: tb/ppdu_end_stats_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus
// directed checks on captured records.
module ppdu_end_stats_bench;
    localparam int DIV  = 2;
    localparam int DURW = 8;
    localparam int DMAX = 255;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, ppdu_start, ppdu_end, mpdu_done, mpdu_fcs_ok, delim_err, rec_ready;
    logic [2:0]  coex_active;
    logic [1:0]  frame_kind;
    logic [7:0]  token_dialog, token_follow;
    logic        rec_valid, rec_last;
    logic [31:0] rec_data;

    ppdu_end_stats #(.TICK_DIV(DIV), .DUR_W(DURW)) u_ppdu_end_stats (
        .clk(clk), .rst_n(rst_n), .ppdu_start(ppdu_start), .ppdu_end(ppdu_end),
        .mpdu_done(mpdu_done), .mpdu_fcs_ok(mpdu_fcs_ok), .delim_err(delim_err),
        .coex_active(coex_active), .frame_kind(frame_kind),
        .token_dialog(token_dialog), .token_follow(token_follow),
        .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_data(rec_data), .rec_last(rec_last)
    );

    int errors = 0;
    int checks = 0;
    int cyc_n  = 0;
    bit stall  = 1'b0;

    // Reference model state
    bit              m_init = 1'b0;
    int              m_dv, m_ph, m_idx, m_dur;
    longint unsigned m_ts, m_tss, m_tse;
    int              m_cnt[4];
    bit [2:0]        m_from, m_aft, m_cq;
    bit              m_bnd, m_dl;
    bit [1:0]        m_fk;
    bit [7:0]        m_td, m_tf;

    always @(posedge clk) begin : ref_model
        bit tick;
        bit [2:0] rise;
        bit aft;
        int k;
        if (!rst_n) begin
            m_init = 1'b1; m_dv = 0; m_ts = 0; m_ph = 0; m_idx = 0; m_dur = 0;
            m_tss = 0; m_tse = 0; m_from = 0; m_aft = 0; m_cq = 0; m_bnd = 0; m_dl = 0;
            m_fk = 0; m_td = 0; m_tf = 0;
            for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        end else begin
            tick = (m_dv == DIV - 1);
            rise = coex_active & ~m_cq;
            if (m_ph == 0) begin
                if (ppdu_start) begin
                    m_ph = 1; m_tss = m_ts; m_from = coex_active; m_aft = 0;
                    m_bnd = |coex_active; m_dl = 0; m_dur = 0;
                    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
                end
            end else if (m_ph == 1) begin
                m_aft = m_aft | rise;
                aft = m_bnd || (rise != 0);
                if (mpdu_done) begin
                    k = (aft ? 2 : 0) + (mpdu_fcs_ok ? 0 : 1);
                    if (m_cnt[k] < 255) m_cnt[k]++;
                end
                if (rise != 0) m_bnd = 1;
                if (delim_err) m_dl = 1;
                if (tick && m_dur < DMAX) m_dur++;
                if (ppdu_end) begin
                    m_ph = 2; m_idx = 0; m_tse = m_ts; m_fk = frame_kind;
                    if (frame_kind == 2'd0) begin m_td = 8'd254; m_tf = 8'd255; end
                    else begin m_td = token_dialog; m_tf = token_follow; end
                end
            end else begin
                if (rec_ready) begin
                    if (m_idx == 12) m_ph = 0;
                    else m_idx++;
                end
            end
            m_cq = coex_active;
            if (tick) begin m_ts = m_ts + 1; m_dv = 0; end
            else m_dv++;
        end
    end

    function automatic logic [31:0] exp_word(int i);
        case (i)
            0: return m_tss[31:0];
            1: return m_tss[63:32];
            2: return m_tse[31:0];
            3: return m_tse[63:32];
            4: return {7'b0, m_tf, m_td, m_fk, m_dl,
                       m_aft[2], m_from[2], m_aft[1], m_from[1], m_aft[0], m_from[0]};
            5: return {m_cnt[3][7:0], m_cnt[2][7:0], m_cnt[1][7:0], m_cnt[0][7:0]};
            6: return 32'(m_dur);
            12: return 32'hAABB_CCDD;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string word_tag(int i);
        if (i <= 3) return "R7";
        if (i == 4) return "R4/R5/R8";
        if (i == 5) return "R2/R3/R9";
        if (i == 6) return "R6";
        return "R10";
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Captured record words
    logic [31:0] rbuf [13];
    int cap_i = 0;
    int recs  = 0;

    // Per-clock comparison and record capture, away from the active edge
    always @(negedge clk) begin
        if (rst_n && m_init) begin
            chk(rec_valid === (m_ph == 2), "R10 valid", 32'(rec_valid), 32'(m_ph == 2));
            if (m_ph == 2) begin
                chk(rec_data === exp_word(m_idx), word_tag(m_idx), rec_data, exp_word(m_idx));
                chk(rec_last === (m_idx == 12), "R10 last", 32'(rec_last), 32'(m_idx == 12));
            end
            if (rec_valid && rec_ready) begin
                if (cap_i < 13) rbuf[cap_i] = rec_data;
                cap_i++;
                if (rec_last) begin cap_i = 0; recs++; end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 100000) begin
            errors++; checks++;
            $display("FAIL R10 watchdog expired actual=%0d expected<=100000", cyc_n);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick_in();
        @(posedge clk);
        #1;
        ppdu_start = 1'b0; ppdu_end = 1'b0; mpdu_done = 1'b0; delim_err = 1'b0;
        rec_ready = stall ? ~rec_ready : 1'b1;
    endtask

    task automatic do_mpdu(bit ok);
        mpdu_done = 1'b1; mpdu_fcs_ok = ok;
        tick_in();
    endtask

    task automatic wait_rec();
        int target = recs + 1;
        while (recs < target) tick_in();
        tick_in();
    endtask

    initial begin
        rst_n = 1'b0; ppdu_start = 0; ppdu_end = 0; mpdu_done = 0; mpdu_fcs_ok = 0;
        delim_err = 0; rec_ready = 1; coex_active = 0; frame_kind = 0;
        token_dialog = 0; token_follow = 0;
        repeat (3) tick_in();
        rst_n = 1'b1;
        tick_in();
        chk(rec_valid == 1'b0, "R1 reset valid", 32'(rec_valid), 32'h0);

        // Plain PPDU, no coex, kind 0 forcing tokens, delimiter error
        ppdu_start = 1; tick_in();
        repeat (3) do_mpdu(1);
        do_mpdu(0);
        delim_err = 1; tick_in();
        repeat (5) tick_in();
        frame_kind = 2'd0; token_dialog = 8'h12; token_follow = 8'h34;
        ppdu_end = 1; tick_in();
        wait_rec();
        chk(rbuf[5] == 32'h0000_0103, "R2 tally word", rbuf[5], 32'h0000_0103);
        chk(rbuf[4][6] == 1'b1, "R5 delimiter flag", 32'(rbuf[4][6]), 32'h1);
        chk(rbuf[4][24:9] == {8'd255, 8'd254}, "R8 forced tokens", 32'(rbuf[4][24:9]), 32'h0000_FFFE);
        chk(rbuf[12] == 32'hAABB_CCDD, "R10 marker", rbuf[12], 32'hAABB_CCDD);
        for (int i = 7; i < 12; i++) chk(rbuf[i] == 32'h0, "R10 zero word", rbuf[i], 32'h0);
        chk(rbuf[1] == 32'h0 && rbuf[3] == 32'h0, "R7 upper halves", rbuf[3], 32'h0);
        begin
            int diff = int'(rbuf[2] - rbuf[0]);
            int d    = int'(rbuf[6]);
            chk(diff - d <= 1 && d - diff <= 1, "R7/R6 span vs duration", 32'(diff), 32'(d));
        end

        // WAN rises together with a failing MPDU, stalled sink
        stall = 1;
        ppdu_start = 1; tick_in();
        repeat (2) do_mpdu(1);
        do_mpdu(0);
        coex_active[1] = 1; mpdu_done = 1; mpdu_fcs_ok = 0; tick_in();
        do_mpdu(1);
        frame_kind = 2'd1; token_dialog = 8'h21; token_follow = 8'h43;
        ppdu_end = 1; tick_in();
        wait_rec();
        chk(rbuf[5] == 32'h0101_0102, "R3 edge-cycle MPDU after", rbuf[5], 32'h0101_0102);
        chk(rbuf[4][5:0] == 6'b001000, "R4 WAN after flag", 32'(rbuf[4][5:0]), 32'h08);
        chk(rbuf[4][6] == 1'b0, "R5 cleared by new PPDU", 32'(rbuf[4][6]), 32'h0);
        chk(rbuf[4][24:7] == {8'h43, 8'h21, 2'd1}, "R8 FTM tokens", 32'(rbuf[4][24:7]), 32'({8'h43, 8'h21, 2'd1}));
        coex_active = 0; stall = 0;

        // BT on at start, WLAN rises later
        coex_active[0] = 1; tick_in();
        ppdu_start = 1; tick_in();
        tick_in();
        coex_active[2] = 1; tick_in();
        repeat (2) do_mpdu(1);
        frame_kind = 2'd2; ppdu_end = 1; tick_in();
        wait_rec();
        chk(rbuf[5] == 32'h0002_0000, "R3 active at start all after", rbuf[5], 32'h0002_0000);
        chk(rbuf[4][5:0] == 6'b100001, "R4 BT from and WLAN after", 32'(rbuf[4][5:0]), 32'h21);
        coex_active = 0;

        // Saturation, restart attempts, end while idle
        ppdu_start = 1; tick_in();
        repeat (300) do_mpdu(1);
        ppdu_start = 1; tick_in();
        repeat (300) tick_in();
        stall = 1;
        ppdu_end = 1; tick_in();
        ppdu_start = 1; tick_in();
        wait_rec();
        stall = 0;
        chk(rbuf[5] == 32'h0000_00FF, "R9/R11 saturated and not restarted", rbuf[5], 32'h0000_00FF);
        chk(rbuf[6] == 32'(DMAX), "R6 duration saturates", rbuf[6], 32'(DMAX));
        ppdu_end = 1; tick_in();
        repeat (20) tick_in();
        chk(rec_valid == 1'b0 && recs == 4, "R11 ignored start/end", 32'(recs), 32'd4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule